// File: doc/BRIEF.md
# Command Line Assembler for a Serial Text Console

This block sits between a byte-level serial receiver and a command decoder. The serial link runs at 38400 baud, with 8 data bits, no parity, one stop bit and no flow control. Bytes from the receiver go first into a small FIFO, because the receiver cannot be stalled. The block then drains the FIFO one byte per cycle. It folds lower-case letters to upper case and applies backspace editing. It builds a command line that is handed over as a flat buffer plus a length once a carriage return arrives.

The input side has no ready signal. `fifo_full` is advisory. A byte offered while the FIFO is full is discarded and sets a sticky overflow flag, which stays set until `ovf_clear` is pulsed. The output side follows valid/ready rules. `line_valid` rises with the finished line, and `line_len`, `line_data` and `line_too_long` stay frozen until a cycle in which `line_ready` is high. During that hold no byte is taken from the FIFO, so back-pressure from the decoder fills the FIFO and can end in overflow. After the handshake the length returns to zero and assembly of the next line resumes from the buffered bytes.

Top module: `cmdline_rx`

## Requirements
- R1: After reset, `line_valid`, `fifo_full`, `ovf_flag` and `line_too_long` are 0 and `line_len` is 0.
- R2: Characters are stored in arrival order. Character i of a line appears at `line_data[8*i+7:8*i]`. On a carriage return (0x0D), `line_valid` rises with `line_len` equal to the number of stored characters. The carriage return itself is not stored.
- R3: Bytes 0x61 to 0x7A are stored as 0x41 to 0x5A. Every other non-control byte is stored unchanged.
- R4: A backspace byte, either 0x08 or 0x7F, removes the most recently stored character of the current line.
- R5: A backspace on an empty line is ignored, and `line_len` stays 0.
- R6: A line holds at most 16 characters. Further characters are dropped and set `line_too_long`, which stays set until the line is handed over and clears at the handshake.
- R7: While `line_valid` is high and `line_ready` is low, `line_valid`, `line_len` and `line_data` hold their values. The cycle after a handshake, `line_valid` is 0 and `line_len` is 0.
- R8: While a line is held, no byte leaves the 16-entry FIFO. `fifo_full` is 1 exactly when 16 bytes are waiting.
- R9: A byte offered with `in_valid` while `fifo_full` is 1 is discarded and sets `ovf_flag`. The flag stays set until a cycle with `ovf_clear` high, and a new overflow in that same cycle takes priority over the clear.
- R10: Bytes buffered during a hold are processed in order once the line is released, so lines sent back to back are delivered one after the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A received byte is present this cycle |
| in_data | input | BYTE_W | Received byte |
| fifo_full | output | 1 | Receive FIFO holds FIFO_DEPTH bytes |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| ovf_flag | output | 1 | Sticky receive overflow |
| line_valid | output | 1 | A finished line is presented |
| line_ready | input | 1 | Consumer accepts the line |
| line_len | output | LEN_W | Number of characters in the line |
| line_data | output | LINE_MAX*BYTE_W | Line characters, character 0 in the low byte |
| line_too_long | output | 1 | Characters were dropped from this line |

## Verification
Lines are sent in several patterns, and each pattern separates a different fault. Plain text with mixed case exposes folding errors and punctuation next to the letter range ('`' and '{'). Strings with 0x08 and 0x7F in the middle, and at the start, separate correct erasure from underflow of the count. A line longer than 16 characters, followed by a short line, shows whether the drop flag is both raised and cleared. A held line with the FIFO filled and then overrun separates back-pressure from loss. Lines sent back to back show whether buffered bytes keep their order after release.

// File: rtl/cmdline_pkg.sv
package cmdline_pkg;
  localparam logic [7:0] CHAR_CR  = 8'h0D;
  localparam logic [7:0] CHAR_BS  = 8'h08;
  localparam logic [7:0] CHAR_DEL = 8'h7F;
  localparam logic [7:0] LOWER_A  = 8'h61;
  localparam logic [7:0] LOWER_Z  = 8'h7A;
  localparam logic [7:0] CASE_GAP = 8'h20;

  typedef enum logic [1:0] {
    K_STORE = 2'd0,
    K_ERASE = 2'd1,
    K_END   = 2'd2
  } char_kind_t;
endpackage

// File: rtl/cmd_fifo.sv
module cmd_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full     = (cnt_q == CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign do_push  = push && !full;
  assign do_pop   = pop && !empty;
  assign pop_data = mem_q[rd_q];

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
      if (do_pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + CW'(1);
        2'b01:   cnt_q <= cnt_q - CW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/char_fold.sv
module char_fold
  import cmdline_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] raw,
  output logic [W-1:0] folded,
  output char_kind_t   kind
);
  always_comb begin
    if (raw >= W'(LOWER_A) && raw <= W'(LOWER_Z)) folded = raw - W'(CASE_GAP);
    else                                         folded = raw;
    if (raw == W'(CHAR_CR))                              kind = K_END;
    else if (raw == W'(CHAR_BS) || raw == W'(CHAR_DEL))  kind = K_ERASE;
    else                                                 kind = K_STORE;
  end
endmodule

// File: rtl/line_asm.sv
module line_asm
  import cmdline_pkg::*;
#(
  parameter int W        = 8,
  parameter int LINE_MAX = 16,
  parameter int LEN_W    = $clog2(LINE_MAX + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  byte_valid,
  input  logic [W-1:0]          byte_data,
  input  char_kind_t            kind,
  output logic                  byte_take,
  output logic                  line_valid,
  input  logic                  line_ready,
  output logic [LEN_W-1:0]      line_len,
  output logic [LINE_MAX*W-1:0] line_flat,
  output logic                  too_long
);
  logic             valid_q, long_q;
  logic [LEN_W-1:0] len_q;
  logic             room, store_en;

  assign byte_take = byte_valid && !valid_q;
  assign room      = (len_q < LEN_W'(LINE_MAX));
  assign store_en  = byte_take && (kind == K_STORE) && room;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      len_q   <= '0;
      long_q  <= 1'b0;
    end else if (valid_q) begin
      if (line_ready) begin
        valid_q <= 1'b0;
        len_q   <= '0;
        long_q  <= 1'b0;
      end
    end else if (byte_valid) begin
      case (kind)
        K_END:   valid_q <= 1'b1;
        K_ERASE: if (len_q != '0) len_q <= len_q - LEN_W'(1);
        K_STORE: begin
          if (room) len_q  <= len_q + LEN_W'(1);
          else      long_q <= 1'b1;
        end
        default: valid_q <= valid_q;
      endcase
    end
  end

  for (genvar g = 0; g < LINE_MAX; g++) begin : g_slot
    logic [W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                                  slot_q <= '0;
      else if (store_en && len_q == LEN_W'(g))     slot_q <= byte_data;
    end
    assign line_flat[g*W +: W] = slot_q;
  end

  assign line_valid = valid_q;
  assign line_len   = len_q;
  assign too_long   = long_q;
endmodule

// File: rtl/cmdline_rx.sv
module cmdline_rx
  import cmdline_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int FIFO_DEPTH = 16,
  parameter int LINE_MAX   = 16,
  localparam int LEN_W     = $clog2(LINE_MAX + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic [BYTE_W-1:0]          in_data,
  output logic                       fifo_full,
  input  logic                       ovf_clear,
  output logic                       ovf_flag,
  output logic                       line_valid,
  input  logic                       line_ready,
  output logic [LEN_W-1:0]           line_len,
  output logic [LINE_MAX*BYTE_W-1:0] line_data,
  output logic                       line_too_long
);
  logic              f_empty, f_full, take;
  logic [BYTE_W-1:0] head_raw, head_fold;
  char_kind_t        head_kind;
  logic              ovf_q;

  cmd_fifo #(.W(BYTE_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_valid),
    .push_data (in_data),
    .pop       (take),
    .pop_data  (head_raw),
    .empty     (f_empty),
    .full      (f_full)
  );

  char_fold #(.W(BYTE_W)) u_fold (
    .raw    (head_raw),
    .folded (head_fold),
    .kind   (head_kind)
  );

  line_asm #(.W(BYTE_W), .LINE_MAX(LINE_MAX), .LEN_W(LEN_W)) u_line (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (!f_empty),
    .byte_data  (head_fold),
    .kind       (head_kind),
    .byte_take  (take),
    .line_valid (line_valid),
    .line_ready (line_ready),
    .line_len   (line_len),
    .line_flat  (line_data),
    .too_long   (line_too_long)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                 ovf_q <= 1'b0;
    else if (in_valid && f_full) ovf_q <= 1'b1;
    else if (ovf_clear)          ovf_q <= 1'b0;
  end

  assign fifo_full = f_full;
  assign ovf_flag  = ovf_q;
endmodule

// File: rtl/cmdline_rx_chk.sv
module cmdline_rx_chk #(
  parameter int BYTE_W   = 8,
  parameter int LINE_MAX = 16,
  localparam int LEN_W   = $clog2(LINE_MAX + 1)
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_valid,
  input logic                       fifo_full,
  input logic                       ovf_clear,
  input logic                       ovf_flag,
  input logic                       line_valid,
  input logic                       line_ready,
  input logic [LEN_W-1:0]           line_len,
  input logic [LINE_MAX*BYTE_W-1:0] line_data
);
  AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid && !line_ready |=> line_valid && $stable(line_len) && $stable(line_data)); // R7

  AST_HANDOFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    line_valid && line_ready |=> !line_valid && line_len == '0); // R7

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    line_len <= LEN_W'(LINE_MAX)); // R6

  AST_OVF_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && fifo_full |=> ovf_flag); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clear |=> ovf_flag); // R9
endmodule

bind cmdline_rx cmdline_rx_chk #(.BYTE_W(BYTE_W), .LINE_MAX(LINE_MAX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .fifo_full  (fifo_full),
  .ovf_clear  (ovf_clear),
  .ovf_flag   (ovf_flag),
  .line_valid (line_valid),
  .line_ready (line_ready),
  .line_len   (line_len),
  .line_data  (line_data)
);

// File: tb/tb_cmdline_rx.sv
module tb_cmdline_rx;
  localparam int LMAX = 16;

  typedef struct packed {
    logic [LMAX*8-1:0] d;
    logic [4:0]        len;
    logic              tl;
  } exp_t;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             in_valid = 1'b0;
  logic [7:0]       in_data = '0;
  logic             fifo_full;
  logic             ovf_clear = 1'b0;
  logic             ovf_flag;
  logic             line_valid;
  logic             line_ready = 1'b0;
  logic [4:0]       line_len;
  logic [LMAX*8-1:0] line_data;
  logic             line_too_long;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   hold_ack = 1'b0;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  cmdline_rx dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .fifo_full(fifo_full), .ovf_clear(ovf_clear), .ovf_flag(ovf_flag),
    .line_valid(line_valid), .line_ready(line_ready), .line_len(line_len),
    .line_data(line_data), .line_too_long(line_too_long)
  );

  task automatic chk(input bit ok, input string tag, input logic [LMAX*8-1:0] act,
                     input logic [LMAX*8-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Expected line from raw keystrokes, built from R2..R6
  task automatic push_exp(input string s);
    exp_t e;
    logic [7:0] c;
    e = '0;
    for (int i = 0; i < s.len(); i++) begin
      c = s[i];
      if (c >= 8'h61 && c <= 8'h7A) c = c - 8'h20;
      if (c == 8'h0D) break;
      else if (c == 8'h08 || c == 8'h7F) begin
        if (e.len != 0) e.len = e.len - 1;
      end else if (e.len < LMAX) begin
        e.d[e.len*8 +: 8] = c;
        e.len = e.len + 1;
      end else e.tl = 1'b1;
    end
    exp_q.push_back(e);
  endtask

  task automatic drive(input string s);
    for (int i = 0; i < s.len(); i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = s[i];
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic send_line(input string s);
    push_exp(s);
    drive(s);
    wait_idle();
  endtask

  // Monitor: pops expected lines and compares (R2, R6), then accepts (R7)
  initial begin
    exp_t e;
    logic [LMAX*8-1:0] mask;
    forever begin
      @(negedge clk);
      if (line_valid && !hold_ack) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected line", {123'(0), line_len}, '0);
        end else begin
          e = exp_q.pop_front();
          mask = '0;
          for (int k = 0; k < LMAX; k++) if (k < e.len) mask[k*8 +: 8] = 8'hFF;
          chk(line_len == e.len, "R2 line length", {123'(0), line_len}, {123'(0), e.len});
          chk((line_data & mask) == e.d, "R2 line data", line_data & mask, e.d);
          chk(line_too_long == e.tl, "R6 too-long flag", {127'(0), line_too_long}, {127'(0), e.tl});
        end
        line_ready = 1'b1;
        @(negedge clk);
        line_ready = 1'b0;
        chk(!line_valid && line_len == 0, "R7 cleared after handshake",
            {122'(0), line_valid, line_len}, '0);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!line_valid && !fifo_full && !ovf_flag && !line_too_long && line_len == 0,
        "R1 reset state", {123'(0), line_valid, fifo_full, ovf_flag, line_too_long, line_len[0]}, '0);

    send_line("SET 12\r");                 // R2 plain line
    send_line("a{z`Zq1 ,\r");              // R3 folding edges
    send_line("ABX\010C\177D\r");          // R4 both erase codes
    send_line("\010\177AB\r");             // R5 erase on empty line
    send_line("\010\r");                   // R5 empty line length 0
    send_line("abcdefghijklmnopqrs\r");    // R6 overlong line
    send_line("ok\r");                     // R6 flag cleared on next line

    // R10 back-to-back lines
    push_exp("TIME 1\r");
    push_exp("alarm\r");
    push_exp("x\r");
    drive("TIME 1\ralarm\rx\r");
    wait_idle();

    // R8 / R9 hold, fill, overrun
    hold_ack = 1'b1;
    push_exp("X\r");
    drive("X\r");
    while (!line_valid) @(negedge clk);
    drive("abcdefghijklmnop");
    chk(fifo_full == 1'b1, "R8 fifo full after 16 bytes", {127'(0), fifo_full}, 1);
    chk(ovf_flag == 1'b0, "R9 no overflow yet", {127'(0), ovf_flag}, 0);
    chk(line_len == 1 && line_valid, "R8 held line untouched", {123'(0), line_len}, 1);
    drive("q");
    chk(ovf_flag == 1'b1, "R9 overflow raised", {127'(0), ovf_flag}, 1);
    repeat (5) @(negedge clk);
    chk(ovf_flag == 1'b1, "R9 overflow sticky", {127'(0), ovf_flag}, 1);
    ovf_clear = 1'b1;
    @(negedge clk);
    ovf_clear = 1'b0;
    chk(ovf_flag == 1'b0, "R9 overflow cleared", {127'(0), ovf_flag}, 0);
    push_exp("abcdefghijklmnop\r");        // R9 dropped 'q' absent, R10 order kept
    hold_ack = 1'b0;
    repeat (25) @(negedge clk);
    chk(fifo_full == 1'b0, "R8 fifo drained", {127'(0), fifo_full}, 0);
    drive("\r");
    wait_idle();
    chk(ovf_flag == 1'b0, "R9 flag stays clear", {127'(0), ovf_flag}, 0);
    chk(exp_q.size() == 0, "R2 all lines delivered", 128'(exp_q.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule